// File: doc/BRIEF.md
# UART Register Bank with Status and Interrupt Control

This block is the memory-mapped register front end of a UART. A host reaches it through a simple word-addressed register port and gets access to ten registers. Through them it can read the received byte, inspect line status, set up framing, modem and divisor controls, manage interrupts and read the fill levels of both FIFOs. The serial shifters and the FIFO storage sit outside the block. It sees them only as fill levels, a head byte with its error flags, and an idle flag. It drives one-cycle push, pop and flush strobes back to them.

The interrupt control register carries enables in its upper nibble and sticky status in its lower nibble. The status bits clear when the register is read. A single interrupt line is formed from the RX and TX status bits, each gated by its own enable. Writing a zero word to the RX residue register flushes the receive FIFO.

Read replies are handled by a two-state access machine. ACC_IDLE moves to ACC_REPLY on a read request. ACC_REPLY stays in ACC_REPLY while back-to-back reads arrive. ACC_REPLY returns to ACC_IDLE on a cycle with no read. While the machine is in ACC_REPLY the reply data is valid.

Top module: `uart_regbank`

## Requirements
- R1: Registers are decoded at byte offsets: 0x00 data, 0x04 line status, 0x08 modem status, 0x0C line control, 0x10 modem control, 0x14 divisor low, 0x18 divisor high, 0x1C interrupt control, 0x20 TX residue, 0x24 RX residue. Any other offset reads as zero, and writes to it have no effect.
- R2: A read accepted at a clock edge sets bus_rvalid for the following cycle, with bus_rdata holding that read's value. When no read was accepted, bus_rvalid is 0 and bus_rdata is 0.
- R3: Line status reads bit0 = TX FIFO not full (level below DEPTH), bit1 = RX FIFO not empty, bit2 = parity error, bit3 = overrun, bit4 = framing error, bit5 = break, and bit6 = transmitter empty (TX level zero and shifter idle). Bits 2 to 5 read 0 while the RX FIFO is empty.
- R4: In interrupt control, bits [7:4] are enables written from bus_wdata[7:4] and read back. Bit5 enables RX and bit4 enables TX. Bit1 is RX status, set in every cycle in which the RX FIFO is not empty. Bit0 is TX status, set in every cycle in which the TX FIFO is not full. A read returns the value held before that read and clears bits [3:0]. Bits 3:2 read 0, and writes do not change status.
- R5: irq is high exactly when (RX status and enable bit5) or (TX status and enable bit4) holds.
- R6: A write to offset 0x00 raises tx_push in the same cycle, with tx_data = bus_wdata[7:0], provided the TX level is below DEPTH. When the TX FIFO is full, the write is dropped.
- R7: A read of offset 0x00 returns the RX head byte and raises rx_pop in the same cycle when the RX level is nonzero. When the RX FIFO is empty, the read returns 0 and does not pop.
- R8: Writing 0 to the RX residue offset raises rx_flush for that cycle. A nonzero write there does not raise it, and TX residue writes have no effect.
- R9: Line control is an 8-bit read/write register driven on line_ctrl. Its bit5 drives tx_break.
- R10: Modem control is a 5-bit read/write register on modem_ctrl: bit0 DTR, bit1 RTS, bit2 carrier detect, bit3 ring indicator, bit4 loopback. Bits above 4 read 0.
- R11: Divisor low is a 16-bit and divisor high an 8-bit read/write register, driven on div_lo and div_hi.
- R12: Modem status is read-only: bit0 CTS, bit1 DSR, bit2 ring, bit3 carrier, taken from the line inputs.
- R13: TX residue and RX residue read the current tx_level and rx_level.
- R14: After reset all control, enable and status registers are zero, and irq, bus_rvalid and every strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read reply data |
| bus_rvalid | output | 1 | Read reply valid |
| irq | output | 1 | Interrupt request |
| tx_push | output | 1 | Push one byte into the TX FIFO |
| tx_data | output | 8 | Byte to push |
| tx_level | input | 8 | TX FIFO fill count |
| tx_idle | input | 1 | TX shift register idle |
| rx_pop | output | 1 | Pop the RX FIFO head |
| rx_flush | output | 1 | Flush the RX FIFO |
| rx_level | input | 8 | RX FIFO fill count |
| rx_data | input | 8 | RX FIFO head byte |
| rx_err_parity | input | 1 | Head byte parity error |
| rx_err_overrun | input | 1 | Overrun flag |
| rx_err_frame | input | 1 | Head byte framing error |
| rx_err_break | input | 1 | Head byte break |
| line_cts | input | 1 | Clear-to-send line |
| line_dsr | input | 1 | Data-set-ready line |
| line_ri | input | 1 | Ring line |
| line_dcd | input | 1 | Carrier line |
| line_ctrl | output | 8 | Line control register |
| tx_break | output | 1 | Force transmit line to space |
| modem_ctrl | output | 5 | Modem control register |
| div_lo | output | 16 | Divisor low register |
| div_hi | output | 8 | Divisor high register |

## Verification
The assertions assume that the FIFO fill counts never exceed DEPTH. The bench keeps tx_level and rx_level within 0 to DEPTH, and weights them towards the empty and full limits. The assertions also assume that only one register access is made per cycle on a single decoded offset. The stimulus mixes mapped, misaligned and out-of-range offsets and randomises the error flags and line inputs. It issues frequent interrupt-register reads, so clear-on-read races against status that is still being asserted.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    typedef enum logic [3:0] {
        RB_DATA  = 4'd0,
        RB_LSTAT = 4'd1,
        RB_MSTAT = 4'd2,
        RB_LCTRL = 4'd3,
        RB_MCTRL = 4'd4,
        RB_DIVLO = 4'd5,
        RB_DIVHI = 4'd6,
        RB_INTR  = 4'd7,
        RB_TXRES = 4'd8,
        RB_RXRES = 4'd9
    } rb_reg_e;

    localparam int RB_NUM = 10;

    typedef enum logic {
        ACC_IDLE,
        ACC_REPLY
    } acc_state_e;

    // line status bit positions
    localparam int LS_TXNF = 0;
    localparam int LS_RXNE = 1;
    localparam int LS_PAR  = 2;
    localparam int LS_OVR  = 3;
    localparam int LS_FRM  = 4;
    localparam int LS_BRK  = 5;
    localparam int LS_TEMT = 6;
    localparam int LS_W    = 7;

    localparam int BREAK_BIT = 5;

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode #(
    parameter int ADDR_W = 6,
    parameter int NUM    = 10
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM-1:0]    hit
);
    // one hit line per word offset; misaligned offsets match nothing
    for (genvar i = 0; i < NUM; i++) begin : g_hit
        assign hit[i] = sel && (addr == ADDR_W'(i * 4));
    end
endmodule

// File: rtl/uart_rb_ctrl.sv
module uart_rb_ctrl #(
    parameter int LCR_W = 8,
    parameter int MCR_W = 5,
    parameter int DLO_W = 16,
    parameter int DHI_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lcr_we,
    input  logic [LCR_W-1:0] lcr_wd,
    input  logic             mcr_we,
    input  logic [MCR_W-1:0] mcr_wd,
    input  logic             dlo_we,
    input  logic [DLO_W-1:0] dlo_wd,
    input  logic             dhi_we,
    input  logic [DHI_W-1:0] dhi_wd,
    output logic [LCR_W-1:0] lcr_q,
    output logic [MCR_W-1:0] mcr_q,
    output logic [DLO_W-1:0] dlo_q,
    output logic [DHI_W-1:0] dhi_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q <= '0;
            mcr_q <= '0;
            dlo_q <= '0;
            dhi_q <= '0;
        end else begin
            if (lcr_we) lcr_q <= lcr_wd;
            if (mcr_we) mcr_q <= mcr_wd;
            if (dlo_we) dlo_q <= dlo_wd;
            if (dhi_we) dhi_q <= dhi_wd;
        end
    end

    assert_lcr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_we |=> (lcr_q == $past(lcr_wd)));

    assert_mcr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_we |=> $stable(mcr_q));
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq #(
    parameter int EN_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [EN_W-1:0] cfg_wd,
    input  logic            stat_rd,
    input  logic            rx_event,
    input  logic            tx_event,
    output logic [EN_W-1:0] en_q,
    output logic [1:0]      stat_q,
    output logic            irq
);
    // en_q[1] gates RX (register bit5), en_q[0] gates TX (register bit4)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            if (cfg_we) en_q <= cfg_wd;
            if (stat_rd) stat_q <= '0;
            else         stat_q <= stat_q | {rx_event, tx_event};
        end
    end

    assign irq = (stat_q[1] & en_q[1]) | (stat_q[0] & en_q[0]);

    assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (stat_q == 2'b00));

    assert_enable_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (en_q == $past(cfg_wd)));

    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat_q != 2'b00) && (en_q[1:0] != 2'b00)));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              irq,
    output logic              tx_push,
    output logic [CHAR_W-1:0] tx_data,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              tx_idle,
    output logic              rx_pop,
    output logic              rx_flush,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_err_parity,
    input  logic              rx_err_overrun,
    input  logic              rx_err_frame,
    input  logic              rx_err_break,
    input  logic              line_cts,
    input  logic              line_dsr,
    input  logic              line_ri,
    input  logic              line_dcd,
    output logic [7:0]        line_ctrl,
    output logic              tx_break,
    output logic [4:0]        modem_ctrl,
    output logic [15:0]       div_lo,
    output logic [7:0]        div_hi
);
    localparam int EN_W = 4;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [RB_NUM-1:0] hit;
    logic              rd_req, wr_req;
    logic              tx_room, rx_avail;
    logic [EN_W-1:0]   irq_en;
    logic [1:0]        irq_stat;
    logic [LS_W-1:0]   lstat;
    logic [DATA_W-1:0] rd_val;
    acc_state_e        state_q, state_d;

    uart_rb_decode #(.ADDR_W(ADDR_W), .NUM(RB_NUM)) u_decode (
        .sel  (bus_sel),
        .addr (bus_addr),
        .hit  (hit)
    );

    assign rd_req   = bus_sel && !bus_wr;
    assign wr_req   = bus_sel && bus_wr;
    assign tx_room  = (tx_level != FULL_LVL);
    assign rx_avail = (rx_level != '0);

    uart_rb_ctrl #(.LCR_W(8), .MCR_W(5), .DLO_W(16), .DHI_W(8)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .lcr_we (wr_req && hit[RB_LCTRL]),
        .lcr_wd (bus_wdata[7:0]),
        .mcr_we (wr_req && hit[RB_MCTRL]),
        .mcr_wd (bus_wdata[4:0]),
        .dlo_we (wr_req && hit[RB_DIVLO]),
        .dlo_wd (bus_wdata[15:0]),
        .dhi_we (wr_req && hit[RB_DIVHI]),
        .dhi_wd (bus_wdata[7:0]),
        .lcr_q  (line_ctrl),
        .mcr_q  (modem_ctrl),
        .dlo_q  (div_lo),
        .dhi_q  (div_hi)
    );

    assign tx_break = line_ctrl[BREAK_BIT];

    uart_rb_irq #(.EN_W(EN_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (wr_req && hit[RB_INTR]),
        .cfg_wd   (bus_wdata[7:4]),
        .stat_rd  (rd_req && hit[RB_INTR]),
        .rx_event (rx_avail),
        .tx_event (tx_room),
        .en_q     (irq_en),
        .stat_q   (irq_stat),
        .irq      (irq)
    );

    // FIFO strobes act in the cycle of the access
    assign tx_push  = wr_req && hit[RB_DATA] && tx_room;
    assign tx_data  = bus_wdata[CHAR_W-1:0];
    assign rx_pop   = rd_req && hit[RB_DATA] && rx_avail;
    assign rx_flush = wr_req && hit[RB_RXRES] && (bus_wdata == '0);

    always_comb begin
        lstat          = '0;
        lstat[LS_TXNF] = tx_room;
        lstat[LS_RXNE] = rx_avail;
        lstat[LS_PAR]  = rx_avail && rx_err_parity;
        lstat[LS_OVR]  = rx_avail && rx_err_overrun;
        lstat[LS_FRM]  = rx_avail && rx_err_frame;
        lstat[LS_BRK]  = rx_avail && rx_err_break;
        lstat[LS_TEMT] = (tx_level == '0) && tx_idle;
    end

    always_comb begin
        rd_val = '0;
        if (hit[RB_DATA] && rx_avail) rd_val = DATA_W'(rx_data);
        if (hit[RB_LSTAT]) rd_val = DATA_W'(lstat);
        if (hit[RB_MSTAT]) rd_val = DATA_W'({line_dcd, line_ri, line_dsr, line_cts});
        if (hit[RB_LCTRL]) rd_val = DATA_W'(line_ctrl);
        if (hit[RB_MCTRL]) rd_val = DATA_W'(modem_ctrl);
        if (hit[RB_DIVLO]) rd_val = DATA_W'(div_lo);
        if (hit[RB_DIVHI]) rd_val = DATA_W'(div_hi);
        if (hit[RB_INTR])  rd_val = DATA_W'({irq_en, 2'b00, irq_stat});
        if (hit[RB_TXRES]) rd_val = DATA_W'(tx_level);
        if (hit[RB_RXRES]) rd_val = DATA_W'(rx_level);
    end

    // access state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  if (rd_req)  state_d = ACC_REPLY;
            ACC_REPLY: if (!rd_req) state_d = ACC_IDLE;
        endcase
    end

    // outputs of the access machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end

    assign bus_rvalid = (state_q == ACC_REPLY);

    assert_push_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> (tx_level < FULL_LVL));

    assert_pop_avail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rx_level != '0));

    assert_flush_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> (bus_wdata == '0) && (bus_addr == ADDR_W'(36)));

    assert_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    assert_no_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (!bus_rvalid && (bus_rdata == '0)));
endmodule

// File: tb/tb_uart_regbank.sv
`timescale 1ns/1ps
module tb_uart_regbank;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid, irq, tx_push, rx_pop, rx_flush, tx_break;
    logic [7:0]  tx_data;
    logic [7:0]  tx_level = '0, rx_level = '0, rx_data = '0;
    logic        tx_idle = 1'b1;
    logic        e_par = 0, e_ovr = 0, e_frm = 0, e_brk = 0;
    logic        l_cts = 0, l_dsr = 0, l_ri = 0, l_dcd = 0;
    logic [7:0]  line_ctrl, div_hi;
    logic [4:0]  modem_ctrl;
    logic [15:0] div_lo;

    always #2 clk = ~clk;

    uart_regbank dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq), .tx_push(tx_push), .tx_data(tx_data),
        .tx_level(tx_level), .tx_idle(tx_idle), .rx_pop(rx_pop), .rx_flush(rx_flush),
        .rx_level(rx_level), .rx_data(rx_data), .rx_err_parity(e_par),
        .rx_err_overrun(e_ovr), .rx_err_frame(e_frm), .rx_err_break(e_brk),
        .line_cts(l_cts), .line_dsr(l_dsr), .line_ri(l_ri), .line_dcd(l_dcd),
        .line_ctrl(line_ctrl), .tx_break(tx_break), .modem_ctrl(modem_ctrl),
        .div_lo(div_lo), .div_hi(div_hi)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_lcr = 0, m_mcr = 0, m_dlo = 0, m_dhi = 0, m_en = 0;
    int m_st_rx = 0, m_st_tx = 0;
    int m_rvalid = 0, m_rdata = 0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic string req_of(int a);
        case (a)
            0:       return "R7 data read";
            4:       return "R3 line status";
            8:       return "R12 modem status";
            12:      return "R9 line control";
            16:      return "R10 modem control";
            20, 24:  return "R11 divisor";
            28:      return "R4 interrupt control";
            32, 36:  return "R13 residue";
            default: return "R1 unmapped";
        endcase
    endfunction

    function automatic int model_read(int a);
        int lsr;
        bit rxne;
        rxne = (rx_level != 0);
        lsr = (tx_level != DEPTH) | (rxne << 1)
            | ((rxne & e_par) << 2) | ((rxne & e_ovr) << 3)
            | ((rxne & e_frm) << 4) | ((rxne & e_brk) << 5)
            | (((tx_level == 0) & tx_idle) << 6);
        case (a)
            0:  return rxne ? int'(rx_data) : 0;
            4:  return lsr;
            8:  return {l_dcd, l_ri, l_dsr, l_cts};
            12: return m_lcr;
            16: return m_mcr;
            20: return m_dlo;
            24: return m_dhi;
            28: return (m_en << 4) | (m_st_rx << 1) | m_st_tx;
            32: return tx_level;
            36: return rx_level;
            default: return 0;
        endcase
    endfunction

    // one clock: compare registered outputs, drive, compare strobes, advance model
    task automatic tick(bit s, bit w, int a, int d);
        int rv;
        bit rd, wrq;
        check("R2 rvalid", bus_rvalid, m_rvalid);
        check(m_rvalid ? "R2 rdata" : "R2 idle rdata", bus_rdata, m_rdata);
        check("R5 irq", irq, (m_st_rx & ((m_en >> 1) & 1)) | (m_st_tx & (m_en & 1)));
        check("R9 line_ctrl", line_ctrl, m_lcr);
        check("R9 tx_break", tx_break, (m_lcr >> 5) & 1);
        check("R10 modem_ctrl", modem_ctrl, m_mcr);
        check("R11 div_lo", div_lo, m_dlo);
        check("R11 div_hi", div_hi, m_dhi);
        bus_sel = s; bus_wr = w; bus_addr = 6'(a); bus_wdata = 16'(d);
        rd  = s && !w;
        wrq = s && w;
        #1;
        check("R6 tx_push", tx_push, wrq && a == 0 && tx_level != DEPTH);
        if (tx_push) check("R6 tx_data", tx_data, d & 8'hFF);
        check("R7 rx_pop", rx_pop, rd && a == 0 && rx_level != 0);
        check("R8 rx_flush", rx_flush, wrq && a == 36 && (d & 16'hFFFF) == 0);
        rv = model_read(a);
        @(posedge clk);
        m_rvalid = rd;
        m_rdata  = rd ? rv : 0;
        if (rd && a == 28) begin
            m_st_rx = 0; m_st_tx = 0;
        end else begin
            m_st_rx = m_st_rx | (rx_level != 0);
            m_st_tx = m_st_tx | (tx_level != DEPTH);
        end
        if (wrq) begin
            case (a)
                12: m_lcr = d & 8'hFF;
                16: m_mcr = d & 5'h1F;
                20: m_dlo = d & 16'hFFFF;
                24: m_dhi = d & 8'hFF;
                28: m_en  = (d >> 4) & 4'hF;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    function automatic logic [7:0] pick_level();
        int r = $urandom % 4;
        if (r == 0) return 8'd0;
        if (r == 1) return 8'(DEPTH);
        return 8'($urandom % (DEPTH + 1));
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R14: reset values
        check("R14 rvalid", bus_rvalid, 0);
        check("R14 irq", irq, 0);
        check("R14 line_ctrl", line_ctrl, 0);
        check("R14 modem_ctrl", modem_ctrl, 0);
        check("R14 div", {div_hi, div_lo}, 0);
        check("R14 strobes", {tx_push, rx_pop, rx_flush}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9/R10/R11 write and read back
        tick(1, 1, 12, 16'hFF2A);
        tick(1, 0, 12, 0);
        tick(1, 1, 16, 16'hFFFF);
        tick(1, 0, 16, 0);
        tick(1, 1, 20, 16'hBEEF);
        tick(1, 1, 24, 16'h1234);
        tick(1, 0, 20, 0);
        tick(1, 0, 24, 0);
        // R4/R5: enables, status and clear-on-read
        tx_level = 8'(DEPTH); rx_level = 0;
        tick(1, 0, 28, 0);
        tick(1, 1, 28, 16'h00F3);
        tick(0, 0, 0, 0);
        rx_level = 8'd5;
        tick(0, 0, 0, 0);
        tick(1, 0, 28, 0);
        rx_level = 0;
        tick(1, 0, 28, 0);
        tick(0, 0, 0, 0);
        // R6: push when full is dropped, otherwise pushed
        tick(1, 1, 0, 16'h0041);
        tx_level = 8'd3;
        tick(1, 1, 0, 16'h0042);
        // R7: read data empty and non-empty
        rx_data = 8'h5A;
        tick(1, 0, 0, 0);
        rx_level = 8'd1;
        tick(1, 0, 0, 0);
        // R3: error flags masked when empty, shown when not
        e_par = 1; e_brk = 1; rx_level = 0; tx_level = 0; tx_idle = 1;
        tick(1, 0, 4, 0);
        rx_level = 8'd2; tx_idle = 0;
        tick(1, 0, 4, 0);
        // R8: flush only on zero
        tick(1, 1, 36, 0);
        tick(1, 1, 36, 16'h0100);
        tick(1, 1, 32, 0);
        // R12/R13
        l_cts = 1; l_dcd = 1;
        tick(1, 0, 8, 0);
        tick(1, 0, 32, 0);
        tick(1, 0, 36, 0);
        // R1: unmapped and misaligned
        tick(1, 1, 40, 16'hFFFF);
        tick(1, 0, 13, 0);
        tick(1, 0, 60, 0);
        tick(1, 0, 12, 0);

        for (int n = 0; n < 3000; n++) begin
            int r, a, d;
            r = $urandom % 16;
            if (r < 10)      a = r * 4;
            else if (r < 13) a = $urandom % 64;
            else             a = 28;
            d = ($urandom % 4 == 0) ? 0 : int'($urandom % 65536);
            tx_level = pick_level();
            rx_level = pick_level();
            rx_data  = 8'($urandom);
            {e_par, e_ovr, e_frm, e_brk} = 4'($urandom);
            {l_cts, l_dsr, l_ri, l_dcd} = 4'($urandom);
            tx_idle = 1'($urandom);
            tick(($urandom % 4) != 0, 1'($urandom), a, d);
        end
        tick(0, 0, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule